// File: doc/BRIEF.md
# Edge-Selectable External Event Counter

This block counts transitions on an external, asynchronous input pin using only the system clock. The pin is resynchronised and then edge-detected. Software picks whether rising or falling transitions count. Each counted transition advances an 8-bit counter. When a counted transition arrives while the counter already equals a software-chosen limit, the counter returns to zero and keeps counting. In the same clock it raises a single-cycle interrupt pulse, so the interrupt rate is the event rate divided by (limit + 1).

Software programs the block through a two-address write port. Address 0 holds the control byte: bit 7 is the run enable and bit 1 selects the counted edge. Address 1 holds the compare limit. The intended order is to clear the run bit, choose the edge, load the limit, and then set the run bit. The live count is available on an output bus, so it can be read at any time.

Top module: `evt_counter_top`

## Requirements
- R1: After reset the count output is 00h, the interrupt output is low, the run bit is 0 and the compare limit is 00h.
- R2: While the run bit (control bit 7) is 0, the count is held at 00h and no interrupt is raised, whatever the event input does.
- R3: With control bit 1 = 0 and the block running, each low-to-high transition of the event input adds exactly one to the count, and high-to-low transitions have no effect on the count.
- R4: With control bit 1 = 1 and the block running, each high-to-low transition adds exactly one, and low-to-high transitions have no effect on the count.
- R5: A counted transition that arrives while the count equals the compare limit sets the count to 00h. In that same clock, the interrupt output goes high for exactly one cycle. Otherwise the count increments and no interrupt is raised.
- R6: With a compare limit of 00h, every counted transition raises an interrupt and the count stays at 00h.
- R7: With a compare limit of FFh, the count reaches FFh and the next counted transition returns it to 00h with one interrupt.
- R8: Clearing and then setting the run bit restarts counting from 00h, and no interrupt is produced by the restart itself.
- R9: A write to the compare limit while running is used from the next counted transition on.
- R10: The count changes on the third rising clock edge after the event input changes, and not before: two synchroniser flops, then the counter register.
- R11: A level held on the event input for any number of cycles produces at most one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control byte, 1 compare limit |
| wr_data | input | 8 | Write data |
| ext_evt | input | 1 | Asynchronous external event input |
| count_q | output | 8 | Current count value |
| irq | output | 1 | One-cycle interrupt pulse on compare match |

## Verification
A wrong count value shows on `count_q` three clocks after the transition that caused it. It stays visible until the next counted transition, so a missed or doubled count is observable at once. A corrupted compare path is different: it only appears at the wrap point, where the interrupt is missing or is raised on the wrong transition. Finding it therefore needs a sweep that runs each limit through at least two full periods, with the expected count and interrupt total derived arithmetically from the number of valid transitions. Synchroniser length faults are caught by sampling the count just before and just after the third clock edge.

// File: rtl/evt_cnt_pkg.sv
// Package: shared constants and types for the external event counter.
// Assumes: the control byte is at least 8 bits wide.
package evt_cnt_pkg;
    // Register addresses on the write port
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CMP  = 1'b1;

    // Bit positions inside the control byte
    localparam int RUN_BIT  = 7;
    localparam int EDGE_BIT = 1;

    // Decoded control settings
    typedef struct packed {
        logic run;        // counter enabled
        logic fall_sel;   // 1: count falling transitions, 0: rising
    } ctrl_t;
endpackage

// File: rtl/evt_sync_edge.sv
// Module: evt_sync_edge
// Resynchronises an asynchronous input through STAGES flops and produces
// one-cycle rise and fall strobes by comparing against the previous sample.
// Assumes: STAGES >= 2; input may change at any time relative to clk.
module evt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] stage_q;
    logic              prev_q;

    // First flop samples the pin directly
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= async_in;
    end

    // Remaining synchroniser flops
    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= 1'b0;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    endgenerate

    // Previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= stage_q[STAGES-1];
    end

    // Edge strobes from current and previous levels
    always_comb begin
        rise = stage_q[STAGES-1] & ~prev_q;
        fall = ~stage_q[STAGES-1] & prev_q;
    end

    // R11
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R11
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/evt_cfg_regs.sv
// Module: evt_cfg_regs
// Holds the control byte fields and the compare limit written over a
// simple address/data strobe port.
// Assumes: writes are single-cycle strobes; only two addresses exist.
module evt_cfg_regs
    import evt_cnt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] cmp_val
);
    // Control fields capture on a control-address write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl.run      <= wr_data[RUN_BIT];
            ctrl.fall_sel <= wr_data[EDGE_BIT];
        end
    end

    // Compare limit captures on a compare-address write
    always_ff @(posedge clk) begin
        if (!rst_n)                             cmp_val <= '0;
        else if (wr_en && wr_addr == ADDR_CMP)  cmp_val <= wr_data;
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl == '0 && cmp_val == '0));
endmodule

// File: rtl/evt_count_core.sv
// Module: evt_count_core
// Counts qualified events, clears on compare match and raises a one-cycle
// interrupt in the same clock as the clear. Held at zero while stopped.
// Assumes: evt is a single-cycle strobe already qualified by edge select.
module evt_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             evt,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count_q,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic hit;

    // Match against the live compare limit
    always_comb hit = (count_q == cmp_val);

    // Count register with hold-at-zero, increment and match clear
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (!run)       count_q <= '0;
        else if (evt && hit) count_q <= '0;
        else if (evt)        count_q <= count_q + ONE;
    end

    // Interrupt pulse registered alongside the clear
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= run & evt & hit;
    end

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count_q == '0 && !irq));
    // R5
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> count_q == '0);
    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !evt) |=> (run && $stable(count_q)) || !run);
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && evt && !hit) |=> count_q == $past(count_q) + ONE);
endmodule

// File: rtl/evt_counter_top.sv
// Module: evt_counter_top
// External event counter: synchronised pin, selectable counted edge,
// compare-match clear with interrupt.
// Assumes: edge select and limit are set before run; limit may change live.
module evt_counter_top
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_evt,
    output logic [CNT_W-1:0] count_q,
    output logic             irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp_val;
    logic             rise;
    logic             fall;
    logic             evt;

    evt_cfg_regs #(.DATA_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .cmp_val (cmp_val)
    );

    evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_evt),
        .rise     (rise),
        .fall     (fall)
    );

    // Pick the counted edge from the control setting
    always_comb evt = ctrl.fall_sel ? fall : rise;

    evt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .evt     (evt),
        .cmp_val (cmp_val),
        .count_q (count_q),
        .irq     (irq)
    );

    // R4
    edge_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && ctrl.fall_sel && rise && count_q != cmp_val)
            |=> $stable(count_q) || !ctrl.run);
endmodule

// File: tb/sim_evt_counter_top.sv
module sim_evt_counter_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_evt = 1'b0;
    logic [7:0] count_q;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int cycles = 0;

    // Reference state
    int  m_cnt = 0;
    int  m_cmp = 0;
    int  m_irq = 0;
    bit  m_run = 0;
    bit  m_fall = 0;

    always #2 clk = ~clk;

    evt_counter_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_evt(ext_evt), .count_q(count_q), .irq(irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 1'b0) begin
            m_run = d[7]; m_fall = d[1];
            if (!m_run) m_cnt = 0;
        end else begin
            m_cmp = d;
        end
    endtask

    // Drive the pin, update the reference, wait out the latency, compare
    task automatic drive(bit v, string req);
        bit valid;
        @(negedge clk);
        valid = m_fall ? (ext_evt && !v) : (!ext_evt && v);
        ext_evt = v;
        if (m_run && valid) begin
            if (m_cnt == m_cmp) begin m_cnt = 0; m_irq++; end
            else m_cnt = (m_cnt + 1) % 256;
        end
        repeat (5) @(negedge clk);
        chk(req, count_q, m_cnt);
        chk(req, irq_seen, m_irq);
    endtask

    // Run a limit through two full periods plus one event
    task automatic sweep(int lim, bit fall_mode, string req);
        wr(1'b0, 8'h00);
        wr(1'b0, fall_mode ? 8'h02 : 8'h00);
        wr(1'b1, lim[7:0]);
        wr(1'b0, fall_mode ? 8'h82 : 8'h80);
        for (int k = 0; k < 2 * (lim + 1) + 1; k++) begin
            drive(!ext_evt, req);
            drive(!ext_evt, req);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", count_q, 0);
        chk("R1", irq, 0);
        // R1 limit 00h after reset: first counted edge wraps immediately
        wr(1'b0, 8'h80);
        drive(1'b1, "R1");
        drive(1'b0, "R1");
        wr(1'b0, 8'h00);

        // R2 stopped: edges ignored
        for (int k = 0; k < 4; k++) drive(!ext_evt, "R2");

        // R3 rising sweeps for small limits, R6 with limit 0
        sweep(0, 1'b0, "R6");
        for (int lim = 1; lim <= 5; lim++) sweep(lim, 1'b0, "R3");
        // R4 falling sweeps
        for (int lim = 0; lim <= 3; lim++) sweep(lim, 1'b1, "R4");
        // R5 mid limit
        sweep(9, 1'b0, "R5");
        // R7 full-range limit
        sweep(255, 1'b0, "R7");

        // R8 restart from zero after stop
        wr(1'b1, 8'd20);
        wr(1'b0, 8'h80);
        if (ext_evt) drive(1'b0, "R8");
        for (int k = 0; k < 4; k++) drive(!ext_evt, "R8");
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h80);
        repeat (3) @(negedge clk);
        chk("R8", count_q, 0);
        chk("R8", irq_seen, m_irq);
        if (ext_evt) drive(1'b0, "R8");
        drive(1'b1, "R8");
        chk("R8", count_q, 1);

        // R9 live limit change: count 1, limit 20 -> 2
        drive(1'b0, "R9");
        wr(1'b1, 8'd2);
        drive(1'b1, "R9");
        chk("R9", count_q, 2);
        drive(1'b0, "R9");
        drive(1'b1, "R9");
        chk("R9", count_q, 0);

        // R10 latency: count at third clock edge after pin change
        drive(1'b0, "R10");
        @(negedge clk);
        ext_evt = 1'b1;
        m_cnt = (m_cnt == m_cmp) ? 0 : m_cnt + 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10", count_q, (m_cnt == 0) ? m_cmp : m_cnt - 1);
        @(posedge clk); @(negedge clk);
        chk("R10", count_q, m_cnt);

        // R11 long held level gives one count only
        drive(1'b0, "R11");
        wr(1'b1, 8'd200);
        drive(1'b1, "R11");
        repeat (50) @(negedge clk);
        chk("R11", count_q, m_cnt);

        finish_run();
    end
endmodule